// File: doc/BRIEF.md
# Function-unit dependency matrix

This block is the hazard tracker for a set of N function units in an out-of-order core. Arithmetic units and load/store units each own one row and one column of a square matrix of single-bit cells. When an operation issues, the block assigns it the lowest-numbered idle unit. That unit's row records two things: which busy units produce its operands (read-after-write), and which busy units must write before it (write-after-write). Each unit gets a go-read enable that lets it fetch operands, and a go-write enable that lets it commit its buffered result. Either enable is held low while any relevant cell in the unit's row is set.

A unit may start executing as soon as its operands are readable, even when commit is still blocked. Commit can also be held by a per-unit write-prevention shadow. A unit carries the shadow when its outcome is still uncertain, such as a memory access that may fault or a speculative path. The shadow is dropped once the outcome is known. A kill input flushes a mis-speculated unit. When a unit commits or is killed, its column is erased from every row at once, so waiting units see the release on the next clock. A build-time option keeps commit in program order: each new operation also waits on every unit already in flight.

Top module: `fu_dep_matrix`

## Requirements
- R1: After reset every unit is idle, `busy`, `go_read` and `go_write` are all zero, `issue_ready` is 1 and `issue_unit` is 0.
- R2: `issue_unit` shows the lowest-numbered idle unit. An issue with `issue_valid` high loads that unit, which shows `busy` from the next clock.
- R3: When all units are busy, `issue_ready` is 0, `issue_unit` is 0, and `issue_valid` has no effect on `busy`.
- R4: `go_read[i]` is 1 only when unit i is busy, has not yet read its operands, and has no read-after-write cell set. A cell for producer j is cleared the clock after j is freed.
- R5: `rd_done[i]` is honoured only while `go_read[i]` is 1. It ends the read phase, and `go_read[i]` falls on the next clock.
- R6: `go_write[i]` is 1 only when unit i has read its operands, holds no shadow, and has no write-after-write cell set.
- R7: `wr_done[i]` while `go_write[i]` is 1 frees unit i on the next clock and clears column i in every row. `wr_done[i]` without `go_write[i]` is ignored.
- R8: An issue with `issue_shadow` high holds that unit's `go_write` low until `shadow_rel` for the unit is pulsed. The shadow does not block `go_read`.
- R9: `kill[i]` on a busy unit frees it on the next clock and clears column i in every row. `kill` on an idle unit is ignored.
- R10: Dependency bits in `issue_raw` and `issue_waw` are recorded only for units that are busy and not being freed in the issue cycle.
- R11: With `ORDER_COMMIT` = 1, each issued operation also waits to write on every unit busy at its issue, so `go_write` is granted in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Request to issue one operation |
| issue_raw | input | N | Units whose results the new operation reads |
| issue_waw | input | N | Units that must write before the new operation |
| issue_shadow | input | 1 | New operation starts with its commit held |
| issue_ready | output | 1 | At least one idle unit exists |
| issue_unit | output | clog2(N) | Unit the next issue would take |
| rd_done | input | N | Unit has read its operands |
| wr_done | input | N | Unit has written its result |
| shadow_rel | input | N | Drop the unit's write-prevention shadow |
| kill | input | N | Flush the unit |
| busy | output | N | Unit holds an operation |
| go_read | output | N | Unit may read its operands |
| go_write | output | N | Unit may commit its result |

## Verification
The assertions check on every cycle the effects that follow one clock behind a cause. A committed or killed unit is idle on the next clock, and its column is empty in every row. A freshly loaded unit starts in the read phase. A shadowed load cannot write on its next clock. Only the bench's scenarios can show the allocation order, the refusal of an issue when all units are busy, and the ignoring of done or kill pulses without a matching grant. The same holds for the masking of dependencies on units freed in the issue cycle, and for in-order commit with the ordering option.

// File: rtl/fudm_pkg.sv
package fudm_pkg;

    // Life of one function-unit row.
    typedef enum logic [1:0] {
        ROW_IDLE  = 2'd0,
        ROW_READ  = 2'd1,
        ROW_WRITE = 2'd2
    } row_phase_e;

endpackage

// File: rtl/fudm_pick.sv
module fudm_pick #(
    parameter int unsigned N  = 4,
    localparam int unsigned UW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  free_vec,
    output logic          any_free,
    output logic [UW-1:0] pick_idx,
    output logic [N-1:0]  pick_hot
);
    always_comb begin
        any_free = 1'b0;
        pick_idx = '0;
        pick_hot = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (free_vec[k]) begin
                any_free = 1'b1;
                pick_idx = UW'(k);
                pick_hot = N'(1) << k;
            end
        end
    end
endmodule

// File: rtl/fudm_row.sv
module fudm_row
    import fudm_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_raw,
    input  logic [N-1:0] load_waw,
    input  logic         load_shadow,
    input  logic [N-1:0] rel_col,
    input  logic         rd_done,
    input  logic         wr_done,
    input  logic         shadow_rel,
    input  logic         kill,
    output logic         busy,
    output logic         go_read,
    output logic         go_write,
    output logic         freed,
    output logic [N-1:0] dep_bits
);
    typedef struct packed {
        row_phase_e   phase;
        logic         shadow;
        logic [N-1:0] raw;
        logic [N-1:0] waw;
    } row_t;

    row_t st_d, st_q;

    assign busy     = (st_q.phase != ROW_IDLE);
    assign go_read  = (st_q.phase == ROW_READ) && (st_q.raw == '0);
    assign go_write = (st_q.phase == ROW_WRITE) && !st_q.shadow && (st_q.waw == '0);
    assign freed    = (kill && busy) || (wr_done && go_write);
    assign dep_bits = st_q.raw | st_q.waw;

    always_comb begin
        st_d = st_q;
        st_d.raw = st_q.raw & ~rel_col;
        st_d.waw = st_q.waw & ~rel_col;
        if (rd_done && go_read) begin
            st_d.phase = ROW_WRITE;
        end
        if (shadow_rel) begin
            st_d.shadow = 1'b0;
        end
        if (freed) begin
            st_d = '0;
        end
        if (load) begin
            st_d.phase  = ROW_READ;
            st_d.shadow = load_shadow;
            st_d.raw    = load_raw;
            st_d.waw    = load_waw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done && go_write |=> !busy);
    // R9
    kill_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill && busy |=> !busy);
    // R2
    load_enters_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy && !go_write);
    // R8
    shadow_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && load_shadow |=> !go_write);
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
    parameter int unsigned N            = 4,
    parameter bit          ORDER_COMMIT = 1'b0,
    localparam int unsigned UW          = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [N-1:0]  issue_raw,
    input  logic [N-1:0]  issue_waw,
    input  logic          issue_shadow,
    output logic          issue_ready,
    output logic [UW-1:0] issue_unit,
    input  logic [N-1:0]  rd_done,
    input  logic [N-1:0]  wr_done,
    input  logic [N-1:0]  shadow_rel,
    input  logic [N-1:0]  kill,
    output logic [N-1:0]  busy,
    output logic [N-1:0]  go_read,
    output logic [N-1:0]  go_write
);
    logic [N-1:0] rel_vec;
    logic [N-1:0] pick_hot;
    logic [N-1:0] keep_vec;
    logic [N-1:0] raw_load;
    logic [N-1:0] waw_load;
    logic [N-1:0] dep_row [N];
    logic [N-1:0] col_any;

    fudm_pick #(.N(N)) u_pick (
        .free_vec (~busy),
        .any_free (issue_ready),
        .pick_idx (issue_unit),
        .pick_hot (pick_hot)
    );

    // Only units that stay busy past this edge may be waited on.
    assign keep_vec = busy & ~rel_vec;
    assign raw_load = issue_raw & keep_vec;

    generate
        if (ORDER_COMMIT) begin : g_ordered
            assign waw_load = (issue_waw | busy) & keep_vec;
        end else begin : g_free_order
            assign waw_load = issue_waw & keep_vec;
        end
    endgenerate

    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            fudm_row #(.N(N)) u_row (
                .clk         (clk),
                .rst_n       (rst_n),
                .load        (issue_valid && pick_hot[i]),
                .load_raw    (raw_load),
                .load_waw    (waw_load),
                .load_shadow (issue_shadow),
                .rel_col     (rel_vec),
                .rd_done     (rd_done[i]),
                .wr_done     (wr_done[i]),
                .shadow_rel  (shadow_rel[i]),
                .kill        (kill[i]),
                .busy        (busy[i]),
                .go_read     (go_read[i]),
                .go_write    (go_write[i]),
                .freed       (rel_vec[i]),
                .dep_bits    (dep_row[i])
            );
        end
    endgenerate

    always_comb begin
        col_any = '0;
        for (int r = 0; r < N; r++) begin
            col_any = col_any | dep_row[r];
        end
    end

    generate
        for (genvar j = 0; j < N; j++) begin : g_col_chk
            // R7 R9
            column_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rel_vec[j] |=> !col_any[j]);
        end
    endgenerate
endmodule

// File: tb/test_fu_dep_matrix.sv
module test_fu_dep_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       iv, ish;
    logic [3:0] iraw, iwaw, rd, wr, srel, kl;
    logic       rdy;
    logic [1:0] unit;
    logic [3:0] bsy, gr, gw;

    logic       o_iv;
    logic [3:0] o_rd, o_wr;
    logic       o_rdy;
    logic [1:0] o_unit;
    logic [3:0] o_bsy, o_gr, o_gw;

    fu_dep_matrix #(.N(4), .ORDER_COMMIT(1'b0)) i_fu_dep_matrix (
        .clk(clk), .rst_n(rst_n), .issue_valid(iv), .issue_raw(iraw),
        .issue_waw(iwaw), .issue_shadow(ish), .issue_ready(rdy),
        .issue_unit(unit), .rd_done(rd), .wr_done(wr), .shadow_rel(srel),
        .kill(kl), .busy(bsy), .go_read(gr), .go_write(gw)
    );

    fu_dep_matrix #(.N(4), .ORDER_COMMIT(1'b1)) i_fu_dep_matrix_ord (
        .clk(clk), .rst_n(rst_n), .issue_valid(o_iv), .issue_raw(4'b0),
        .issue_waw(4'b0), .issue_shadow(1'b0), .issue_ready(o_rdy),
        .issue_unit(o_unit), .rd_done(o_rd), .wr_done(o_wr),
        .shadow_rel(4'b0), .kill(4'b0), .busy(o_bsy), .go_read(o_gr),
        .go_write(o_gw)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       iv;
        logic [3:0] raw;
        logic [3:0] waw;
        logic       sh;
        logic [3:0] rd;
        logic [3:0] wr;
        logic [3:0] srel;
        logic [3:0] kl;
        logic [3:0] e_busy;
        logic [3:0] e_gr;
        logic [3:0] e_gw;
        logic       e_rdy;
        logic [1:0] e_unit;
    } vec_t;

    // req, iv, raw, waw, sh, rd, wr, srel, kl | busy, go_read, go_write, ready, unit
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b1, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 1'b1, 2'd1}, // R2 first issue
        '{4'd4,  1'b1, 4'b0001, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0011, 4'b0001, 4'b0000, 1'b1, 2'd2}, // R4 waits on unit 0
        '{4'd5,  1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0011, 4'b0000, 4'b0001, 1'b1, 2'd2}, // R5 rd on blocked unit ignored
        '{4'd6,  1'b1, 4'b0000, 4'b0001, 1'b1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0111, 4'b0100, 4'b0001, 1'b1, 2'd3}, // R6 waw, shadowed
        '{4'd7,  1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0111, 4'b0100, 4'b0001, 1'b1, 2'd3}, // R7 wr without grant
        '{4'd7,  1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0110, 4'b0110, 4'b0000, 1'b1, 2'd0}, // R7 commit clears column
        '{4'd8,  1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0110, 4'b0000, 4'b0010, 1'b1, 2'd0}, // R8 shadow blocks write
        '{4'd8,  1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0100, 4'b0000, 4'b0110, 4'b0000, 4'b0110, 1'b1, 2'd0}, // R8 shadow released
        '{4'd4,  1'b1, 4'b0110, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0111, 4'b0000, 4'b0110, 1'b1, 2'd3}, // R4 two producers
        '{4'd10, 1'b1, 4'b1010, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b1101, 4'b1000, 4'b0100, 1'b1, 2'd1}, // R10 R9 kill plus masked issue
        '{4'd9,  1'b1, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b1111, 4'b1010, 4'b0100, 1'b0, 2'd0}, // R9 kill on idle ignored
        '{4'd3,  1'b1, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b1010, 4'b0100, 1'b0, 2'd0}, // R3 refused
        '{4'd7,  1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b1011, 4'b1011, 4'b0000, 1'b1, 2'd2}, // R7 last producer gone
        '{4'd9,  1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b1011, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0}  // R9 flush all
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        iv = 1'b0; ish = 1'b0; iraw = '0; iwaw = '0;
        rd = '0; wr = '0; srel = '0; kl = '0;
        o_iv = 1'b0; o_rd = '0; o_wr = '0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(1, "busy after reset", 32'(bsy), 0);
        chk(1, "go_read after reset", 32'(gr), 0);
        chk(1, "go_write after reset", 32'(gw), 0);
        chk(1, "issue_ready after reset", 32'(rdy), 1);
        chk(1, "issue_unit after reset", 32'(unit), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            iv = VECS[v].iv; iraw = VECS[v].raw; iwaw = VECS[v].waw;
            ish = VECS[v].sh; rd = VECS[v].rd; wr = VECS[v].wr;
            srel = VECS[v].srel; kl = VECS[v].kl;
            step();
            idle_inputs();
            chk(int'(VECS[v].req), $sformatf("vec %0d busy", v), 32'(bsy), 32'(VECS[v].e_busy));
            chk(int'(VECS[v].req), $sformatf("vec %0d go_read", v), 32'(gr), 32'(VECS[v].e_gr));
            chk(int'(VECS[v].req), $sformatf("vec %0d go_write", v), 32'(gw), 32'(VECS[v].e_gw));
            chk(int'(VECS[v].req), $sformatf("vec %0d ready", v), 32'(rdy), 32'(VECS[v].e_rdy));
            chk(int'(VECS[v].req), $sformatf("vec %0d unit", v), 32'(unit), 32'(VECS[v].e_unit));
        end

        // R11 ordered commit: three independent issues, then all read
        for (int k = 0; k < 3; k++) begin
            o_iv = 1'b1;
            step();
            idle_inputs();
        end
        chk(11, "ordered busy", 32'(o_bsy), 32'h7);
        chk(11, "ordered go_read", 32'(o_gr), 32'h7);
        o_rd = 4'b0111;
        step();
        idle_inputs();
        chk(11, "ordered oldest writes first", 32'(o_gw), 32'h1);
        o_wr = 4'b0001;
        step();
        idle_inputs();
        chk(11, "ordered second in line", 32'(o_gw), 32'h2);
        o_wr = 4'b0010;
        step();
        idle_inputs();
        chk(11, "ordered third in line", 32'(o_gw), 32'h4);
        chk(11, "ordered unit after frees", 32'(o_unit), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule